// File: doc/BRIEF.md
# UART Interrupt Identification and Modem Status Unit

This block collects the interrupt sources of a serial port into one request line and one identification code. The sources are receiver line errors, received data (with a stale-data timeout that shares its rank), transmit holding register empty, and changes on the modem control lines. Each source has an enable bit. The identification code names only the most urgent source that is both pending and enabled. The host uses that code to decide which register to read next. Reading that register, or writing the transmit register, clears the source.

The block also keeps the modem status byte. The upper half shows the present levels of the four modem input lines. The lower half holds sticky change flags that clear when the status is read. A loopback control feeds the four modem control outputs back in place of the external modem inputs.

Events, strobes and modem lines are all sampled on the rising clock edge. The outputs come from registered state. A modem line change therefore shows in the status byte one edge after the input changes. An event pulse shows in the request line and the code right after the edge that samples it.

Top module: `uart_irq_id`

## Requirements
- R1: `irq` is high exactly when at least one source is pending and has its enable bit set. The enable bits are: bit 0 for received data and timeout, bit 1 for transmit empty, bit 2 for line error, bit 3 for modem change. When all enable bits are 0, `irq` stays low.
- R2: `iir_o[3:1]` gives the code of the highest-ranked source that is enabled and pending. The ranks and codes are:
  - line error: 3'b011 (highest rank);
  - received data: 3'b010;
  - timeout: 3'b110, used only when the timeout is pending and received data is not;
  - transmit empty: 3'b001;
  - modem change: 3'b000 (lowest rank).
- R3: `iir_o[0]` is 0 while a request is active and 1 otherwise. When nothing is reported, `iir_o` equals 4'b0001. This includes the state after reset.
- R4: `msr_o[7:4]` hold the sampled levels of DCD, RI, DSR and CTS, in that order from bit 7 down to bit 4. These levels are 0 after reset.
- R5: `msr_o[0]` (CTS), `msr_o[1]` (DSR) and `msr_o[3]` (DCD) set whenever the sampled level of the matching line differs from its previous sample. Once set, they stay set until a status read.
- R6: `msr_o[2]` sets only when the sampled RI level goes from 1 to 0. A rise of RI leaves it unchanged.
- R7: A pulse on `rd_msr` clears all four change flags at that edge. A change sampled at the same edge sets its flag anyway.
- R8: A line error stays pending until `rd_lsr`. Received data and timeout stay pending until `rd_rbr`. A new event at the clearing edge keeps the source pending.
- R9: Transmit empty clears on `wr_thr`, or on `rd_iir` at an edge where code 3'b001 is being reported. It does not clear on `rd_iir` while a higher-ranked source is reported. A new `tx_empty_evt` at the same edge keeps it pending.
- R10: While `loop_en` is high, the status byte samples `rts_o` as CTS, `dtr_o` as DSR, `out1_o` as RI and `out2_o` as DCD. The external modem inputs are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 4 | Source enable bits |
| line_err_evt | input | 1 | Receiver line error event pulse |
| rx_avail_evt | input | 1 | Received data available pulse |
| rx_tmo_evt | input | 1 | Stale receive data timeout pulse |
| tx_empty_evt | input | 1 | Transmit holding register became empty |
| rd_lsr | input | 1 | Host read of line status |
| rd_rbr | input | 1 | Host read of received data |
| rd_iir | input | 1 | Host read of the identification code |
| wr_thr | input | 1 | Host write of transmit data |
| rd_msr | input | 1 | Host read of modem status |
| loop_en | input | 1 | Loopback of modem control outputs |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring indicator line |
| dcd_i | input | 1 | Carrier detect line |
| rts_o | input | 1 | Request-to-send control output (from port) |
| dtr_o | input | 1 | Terminal-ready control output |
| out1_o | input | 1 | User output 1 |
| out2_o | input | 1 | User output 2 |
| irq | output | 1 | Interrupt request |
| iir_o | output | 4 | Identification code and active-low pending flag |
| msr_o | output | 8 | Modem status byte |

## Verification
A wrong pending flag shows up on the edge after the event or strobe that touches it. It appears as a wrong code on `iir_o` or a wrong level on `irq`, but only while that source is the highest-ranked enabled one. For that reason, the stimulus changes the enable bits and mixes sources so that lower ranks become visible. A stuck or lost change flag shows in `msr_o[3:0]` one edge after the line changes. The same defect also shows in the modem-rank code once every higher source is clear. Loopback errors show as wrong levels in `msr_o[7:4]`.

// File: rtl/uart_irq_id.sv
module uart_irq_id (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_en,
  input  logic       line_err_evt,
  input  logic       rx_avail_evt,
  input  logic       rx_tmo_evt,
  input  logic       tx_empty_evt,
  input  logic       rd_lsr,
  input  logic       rd_rbr,
  input  logic       rd_iir,
  input  logic       wr_thr,
  input  logic       rd_msr,
  input  logic       loop_en,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       rts_o,
  input  logic       dtr_o,
  input  logic       out1_o,
  input  logic       out2_o,
  output logic       irq,
  output logic [3:0] iir_o,
  output logic [7:0] msr_o
);

  logic       line_q, rx_q, tmo_q, thre_q;
  logic [3:0] lvl_q, dlt_q;
  logic [2:0] id;

  wire [3:0] lines = loop_en ? {out2_o, out1_o, dtr_o, rts_o}
                             : {dcd_i, ri_i, dsr_i, cts_i};
  wire [3:0] dlt_set = {lines[3] ^ lvl_q[3], lvl_q[2] & ~lines[2],
                        lines[1] ^ lvl_q[1], lines[0] ^ lvl_q[0]};

  wire act_line = line_q & irq_en[2];
  wire act_rx   = (rx_q | tmo_q) & irq_en[0];
  wire act_thre = thre_q & irq_en[1];
  wire act_ms   = (|dlt_q) & irq_en[3];
  wire thre_ack = rd_iir & act_thre & ~act_line & ~act_rx;

  always_comb begin
    if (act_line)      id = 3'b011;
    else if (act_rx)   id = rx_q ? 3'b010 : 3'b110;
    else if (act_thre) id = 3'b001;
    else               id = 3'b000;
  end

  assign irq   = act_line | act_rx | act_thre | act_ms;
  assign iir_o = {id, ~irq};
  assign msr_o = {lvl_q, dlt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      rx_q   <= 1'b0;
      tmo_q  <= 1'b0;
      thre_q <= 1'b0;
      lvl_q  <= 4'b0;
      dlt_q  <= 4'b0;
    end else begin
      line_q <= line_err_evt | (line_q & ~rd_lsr);
      rx_q   <= rx_avail_evt | (rx_q & ~rd_rbr);
      tmo_q  <= rx_tmo_evt   | (tmo_q & ~rd_rbr);
      thre_q <= tx_empty_evt | (thre_q & ~wr_thr & ~thre_ack);
      lvl_q  <= lines;
      dlt_q  <= (rd_msr ? 4'b0 : dlt_q) | dlt_set;
    end
  end

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] irq_en,
  input logic       tx_empty_evt,
  input logic       rd_lsr,
  input logic       rd_iir,
  input logic       rd_msr,
  input logic       irq,
  input logic [3:0] iir_o,
  input logic [7:0] msr_o
);

  p_no_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0) |-> !irq);

  p_line_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_o == 4'b0110 && !rd_lsr) |=> (!irq_en[2] || iir_o == 4'b0110));

  p_thre_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iir_o == 4'b0010 && !tx_empty_evt) |=> (iir_o[3:1] != 3'b001));

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_msr) && msr_o[7:4] == $past(msr_o[7:4])) |-> (msr_o[3:0] == 4'b0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msr |=> ((msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0])));

  p_cts_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[4] != $past(msr_o[4])) |-> msr_o[0]);

  p_dsr_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[5] != $past(msr_o[5])) |-> msr_o[1]);

  p_dcd_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[7] != $past(msr_o[7])) |-> msr_o[3]);

  p_ring_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msr_o[6]) && !$past(msr_o[2])) |-> !msr_o[2]);

endmodule

bind uart_irq_id uart_irq_id_chk chk_i (.*);

// File: tb/uart_irq_id_tb_top.sv
module uart_irq_id_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] irq_en = 0;
  logic line_err_evt = 0, rx_avail_evt = 0, rx_tmo_evt = 0, tx_empty_evt = 0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, wr_thr = 0, rd_msr = 0, loop_en = 0;
  logic cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic rts_o = 0, dtr_o = 0, out1_o = 0, out2_o = 0;
  logic irq;
  logic [3:0] iir_o;
  logic [7:0] msr_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  logic m_line = 0, m_rx = 0, m_tmo = 0, m_thre = 0;
  logic [3:0] m_lvl = 0, m_dlt = 0;

  always #4 clk = ~clk;

  uart_irq_id dut_i (.*);

  function automatic logic [2:0] exp_code();
    if (m_line && irq_en[2]) return 3'b011;
    if ((m_rx || m_tmo) && irq_en[0]) return m_rx ? 3'b010 : 3'b110;
    if (m_thre && irq_en[1]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic exp_irq();
    return (m_line && irq_en[2]) || ((m_rx || m_tmo) && irq_en[0]) ||
           (m_thre && irq_en[1]) || ((|m_dlt) && irq_en[3]);
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic model_edge();
    logic [3:0] ln;
    logic ack;
    ln  = loop_en ? {out2_o, out1_o, dtr_o, rts_o} : {dcd_i, ri_i, dsr_i, cts_i};
    ack = rd_iir && exp_code() == 3'b001 && exp_irq();
    m_line = line_err_evt | (m_line & ~rd_lsr);
    m_rx   = rx_avail_evt | (m_rx & ~rd_rbr);
    m_tmo  = rx_tmo_evt | (m_tmo & ~rd_rbr);
    m_thre = tx_empty_evt | (m_thre & ~wr_thr & ~ack);
    m_dlt  = (rd_msr ? 4'b0 : m_dlt) |
             {ln[3] ^ m_lvl[3], m_lvl[2] & ~ln[2], ln[1] ^ m_lvl[1], ln[0] ^ m_lvl[0]};
    m_lvl  = ln;
  endtask

  task automatic compare();
    chk("R1 irq", {7'b0, irq}, {7'b0, exp_irq()});
    chk("R2 code", {5'b0, iir_o[3:1]}, {5'b0, exp_code()});
    chk("R3 pending bit", {7'b0, iir_o[0]}, {7'b0, ~exp_irq()});
    chk("R4/R10 levels", {4'b0, msr_o[7:4]}, {4'b0, m_lvl});
    chk("R5 deltas", {5'b0, msr_o[3], msr_o[1:0]}, {5'b0, m_dlt[3], m_dlt[1:0]});
    chk("R6 ring end", {7'b0, msr_o[2]}, {7'b0, m_dlt[2]});
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    cyc++;
    compare();
    {line_err_evt, rx_avail_evt, rx_tmo_evt, tx_empty_evt} = 0;
    {rd_lsr, rd_rbr, rd_iir, wr_thr, rd_msr} = 0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b2c));
    @(negedge clk); @(negedge clk);
    chk("R3 reset iir", {4'b0, iir_o}, 8'h01);
    chk("R4 reset msr", msr_o, 8'h00);
    rst_n = 1;
    tick();
    irq_en = 4'hF;
    // R8 / R2 ranking
    line_err_evt = 1; rx_avail_evt = 1; tick();
    chk("R2 line first", {4'b0, iir_o}, 8'h06);
    rd_lsr = 1; tick();
    chk("R8 lsr read", {4'b0, iir_o}, 8'h04);
    rd_rbr = 1; tick();
    chk("R8 data read", {4'b0, iir_o}, 8'h01);
    rx_tmo_evt = 1; tick();
    chk("R2 timeout code", {4'b0, iir_o}, 8'h0C);
    rx_avail_evt = 1; tick();
    chk("R2 data over timeout", {4'b0, iir_o}, 8'h04);
    rd_rbr = 1; rx_tmo_evt = 1; tick();
    chk("R8 set wins", {4'b0, iir_o}, 8'h0C);
    rd_rbr = 1; tick();
    // R9
    tx_empty_evt = 1; tick();
    chk("R9 thre", {4'b0, iir_o}, 8'h02);
    rd_iir = 1; tick();
    chk("R9 iir ack", {4'b0, iir_o}, 8'h01);
    tx_empty_evt = 1; line_err_evt = 1; tick();
    rd_iir = 1; tick();
    rd_lsr = 1; tick();
    chk("R9 survives masked ack", {4'b0, iir_o}, 8'h02);
    wr_thr = 1; tick();
    chk("R9 write clears", {4'b0, iir_o}, 8'h01);
    // R5 / R7
    cts_i = 1; tick();
    chk("R5 cts change", msr_o, 8'h11);
    chk("R2 modem code", {4'b0, iir_o}, 8'h00);
    dsr_i = 1; rd_msr = 1; tick();
    chk("R7 set wins", msr_o, 8'h32);
    rd_msr = 1; tick();
    chk("R7 read clears", msr_o, 8'h30);
    // R6
    ri_i = 1; tick();
    chk("R6 ring start", msr_o, 8'h70);
    ri_i = 0; tick();
    chk("R6 ring end", msr_o, 8'h34);
    rd_msr = 1; tick();
    // R10
    loop_en = 1; rts_o = 0; dtr_o = 1; out1_o = 0; out2_o = 1; tick();
    rd_msr = 1; tick();
    chk("R10 loopback", msr_o, 8'hA0);
    dcd_i = 0; cts_i = 1; dsr_i = 0; tick();
    chk("R10 ext ignored", msr_o, 8'hA0);
    loop_en = 0; tick();
    rd_msr = 1; tick();
    // R1
    line_err_evt = 1; irq_en = 4'h0; tick();
    chk("R1 disabled", {7'b0, irq}, 8'h00);
    chk("R3 disabled id", {4'b0, iir_o}, 8'h01);
    rd_lsr = 1; tick();
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 24 == 0) irq_en = 4'($urandom);
      line_err_evt = ($urandom % 14 == 0);
      rx_avail_evt = ($urandom % 10 == 0);
      rx_tmo_evt   = ($urandom % 16 == 0);
      tx_empty_evt = ($urandom % 10 == 0);
      rd_lsr = ($urandom % 6 == 0);
      rd_rbr = ($urandom % 6 == 0);
      rd_iir = ($urandom % 4 == 0);
      wr_thr = ($urandom % 8 == 0);
      rd_msr = ($urandom % 5 == 0);
      if ($urandom % 60 == 0) loop_en = ~loop_en;
      if ($urandom % 12 == 0) cts_i = ~cts_i;
      if ($urandom % 12 == 0) dsr_i = ~dsr_i;
      if ($urandom % 12 == 0) ri_i = ~ri_i;
      if ($urandom % 12 == 0) dcd_i = ~dcd_i;
      if ($urandom % 12 == 0) rts_o = ~rts_o;
      if ($urandom % 12 == 0) dtr_o = ~dtr_o;
      if ($urandom % 12 == 0) out1_o = ~out1_o;
      if ($urandom % 12 == 0) out2_o = ~out2_o;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule